// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block collects up to 32 interrupt sources and decides which one the processor should service next. Each source owns an 8-bit control word holding a pending flag, a local enable, a 4-bit priority level and a 2-bit group value. Among the sources that are pending and enabled, the arbiter picks a winner. Level decides first. Group breaks ties within a level. The source index settles any tie that remains.

The winner is offered to the processor only when the global enable is on and the winner's level is strictly above the level the processor is running at. The result is registered. A one-cycle grant strobe marks each new offer.

Software loads a source's control word through a simple write port. Hardware sets a pending flag when that source signals an event. The flag is cleared when the processor reports that the source has been serviced.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every pending flag is clear, and `win_vld_o`, `gnt_o`, `win_idx_o`, `win_lvl_o` and `win_grp_o` are all zero.
- R2: A write with `cfg_we_i` high loads the control word of source `cfg_idx_i` from `cfg_data_i`, using this layout: bit 7 pending, bit 6 enable, bits 5:2 level, bits 1:0 group.
- R3: A source competes only if its pending flag, its enable and `gie_i` are all 1. A source at level 0 never wins.
- R4: Among competing sources, the one with the numerically largest level wins.
- R5: Among competing sources that share the largest level, the one with the numerically largest group wins.
- R6: When level and group are both equal, the lowest source index wins.
- R7: `win_vld_o` is 1 only when the winner's level is strictly greater than `cpu_lvl_i`.
  - When it is 1, the index, level and group of the winner are shown; otherwise those fields are 0.
  - The outputs appear one clock after the state and inputs they are computed from.
- R8: `gnt_o` is a one-cycle pulse that rises with a valid winner.
  - After a pulse, no further pulse occurs until `cpu_lvl_i` differs from its value in the granting cycle, or until there has been a cycle with no valid winner.
- R9: An event on `evt_i[k]` sets source k's pending flag at the next clock edge.
- R10: `svc_i` clears the pending flag of source `svc_idx_i`.
  - The clear overrides a same-cycle write to that source.
  - An event on the same source in the same cycle overrides the clear, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| evt_i | input | NSRC | Per-source event pulses |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_idx_i | input | IDX_W | Source selected for the write |
| cfg_data_i | input | 8 | Control word to write |
| gie_i | input | 1 | Global interrupt enable |
| cpu_lvl_i | input | 4 | Current processor priority level |
| svc_i | input | 1 | Service acknowledge strobe |
| svc_idx_i | input | IDX_W | Source that was serviced |
| win_vld_o | output | 1 | A winner beats the processor level |
| win_idx_o | output | IDX_W | Index of the winning source |
| win_lvl_o | output | 4 | Level of the winning source |
| win_grp_o | output | 2 | Group of the winning source |
| gnt_o | output | 1 | One-cycle grant strobe |

## Verification
A pending flag that fails to set or clear changes which source is shown one clock after the next edge. This is visible when the affected source would win or lose at that time. A flaw in the comparison tree moves `win_idx_o` away from the index predicted by level, then group, then index, and this shows in the very next registered result. A wrong re-arm state in the grant logic appears as a missing strobe or an extra strobe in the cycle after `cpu_lvl_i` holds or changes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W = 4;
    localparam int GRP_W = 2;
    localparam int KEY_W = LVL_W + GRP_W;
    localparam int CFG_W = 8;

    // Packed order fixes the software layout: pend[7] en[6] lvl[5:2] grp[1:0]
    typedef struct packed {
        logic             pend;
        logic             en;
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
    } src_cfg_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_arb_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NSRC-1:0]       evt_i,
    input  logic                  we_i,
    input  logic [IDX_W-1:0]      widx_i,
    input  src_cfg_t              wcfg_i,
    input  logic                  svc_i,
    input  logic [IDX_W-1:0]      svc_idx_i,
    output src_cfg_t [NSRC-1:0]   cfg_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        src_cfg_t cfg_d, cfg_q;

        always_comb begin
            cfg_d = cfg_q;
            if (we_i && widx_i == IDX_W'(i)) cfg_d = wcfg_i;
            if (svc_i && svc_idx_i == IDX_W'(i)) cfg_d.pend = 1'b0;
            if (evt_i[i]) cfg_d.pend = 1'b1;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) cfg_q <= '0;
            else         cfg_q <= cfg_d;
        end

        assign cfg_o[i] = cfg_q;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  src_cfg_t [NSRC-1:0] cfg_i,
    input  logic                gie_i,
    output logic                cand_vld_o,
    output logic [IDX_W-1:0]    cand_idx_o,
    output logic [LVL_W-1:0]    cand_lvl_o,
    output logic [GRP_W-1:0]    cand_grp_o
);
    localparam int LEAVES = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] key;
        logic [IDX_W-1:0] idx;
    } node_t;

    // Left operand always covers the lower indices: it keeps ties.
    function automatic node_t merge(node_t lo, node_t hi);
        if (hi.vld && (!lo.vld || hi.key > lo.key)) return hi;
        return lo;
    endfunction

    for (genvar s = 0; s <= IDX_W; s++) begin : g_stage
        localparam int N = LEAVES >> s;
        node_t nodes [N];
        if (s == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_l
                if (i < NSRC) begin : g_real
                    assign nodes[i].vld = gie_i & cfg_i[i].pend & cfg_i[i].en
                                          & (cfg_i[i].lvl != '0);
                    assign nodes[i].key = {cfg_i[i].lvl, cfg_i[i].grp};
                    assign nodes[i].idx = IDX_W'(i);
                end else begin : g_pad
                    assign nodes[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < N; j++) begin : g_m
                assign nodes[j] = merge(g_stage[s-1].nodes[2*j], g_stage[s-1].nodes[2*j+1]);
            end
        end
    end

    assign cand_vld_o = g_stage[IDX_W].nodes[0].vld;
    assign cand_idx_o = g_stage[IDX_W].nodes[0].idx;
    assign cand_lvl_o = g_stage[IDX_W].nodes[0].key[KEY_W-1:GRP_W];
    assign cand_grp_o = g_stage[IDX_W].nodes[0].key[GRP_W-1:0];
endmodule

// File: rtl/irq_grant_ctl.sv
module irq_grant_ctl
    import irq_arb_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cand_vld_i,
    input  logic [IDX_W-1:0] cand_idx_i,
    input  logic [LVL_W-1:0] cand_lvl_i,
    input  logic [GRP_W-1:0] cand_grp_i,
    input  logic [LVL_W-1:0] cpu_lvl_i,
    output logic             win_vld_o,
    output logic [IDX_W-1:0] win_idx_o,
    output logic [LVL_W-1:0] win_lvl_o,
    output logic [GRP_W-1:0] win_grp_o,
    output logic             gnt_o
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
        logic             gnt;
        logic             armed;
        logic [LVL_W-1:0] snap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic eligible;
        logic rearm;
        eligible    = cand_vld_i && (cand_lvl_i > cpu_lvl_i);
        rearm       = st_q.armed || (cpu_lvl_i != st_q.snap);
        st_d        = st_q;
        st_d.vld    = eligible;
        st_d.idx    = eligible ? cand_idx_i : '0;
        st_d.lvl    = eligible ? cand_lvl_i : '0;
        st_d.grp    = eligible ? cand_grp_i : '0;
        st_d.gnt    = eligible && rearm;
        st_d.armed  = st_d.gnt ? 1'b0 : (rearm || !eligible);
        st_d.snap   = st_d.gnt ? cpu_lvl_i : st_q.snap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_vld_o = st_q.vld;
    assign win_idx_o = st_q.idx;
    assign win_lvl_o = st_q.lvl;
    assign win_grp_o = st_q.grp;
    assign gnt_o     = st_q.gnt;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NSRC-1:0]  evt_i,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [7:0]       cfg_data_i,
    input  logic             gie_i,
    input  logic [3:0]       cpu_lvl_i,
    input  logic             svc_i,
    input  logic [IDX_W-1:0] svc_idx_i,
    output logic             win_vld_o,
    output logic [IDX_W-1:0] win_idx_o,
    output logic [3:0]       win_lvl_o,
    output logic [1:0]       win_grp_o,
    output logic             gnt_o
);
    src_cfg_t [NSRC-1:0] cfg;
    logic [NSRC-1:0]     pend_vec;
    logic                cand_vld;
    logic [IDX_W-1:0]    cand_idx;
    logic [LVL_W-1:0]    cand_lvl;
    logic [GRP_W-1:0]    cand_grp;

    irq_src_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt_i),
        .we_i      (cfg_we_i),
        .widx_i    (cfg_idx_i),
        .wcfg_i    (src_cfg_t'(cfg_data_i)),
        .svc_i     (svc_i),
        .svc_idx_i (svc_idx_i),
        .cfg_o     (cfg)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_pv
        assign pend_vec[i] = cfg[i].pend;
    end

    irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .cfg_i      (cfg),
        .gie_i      (gie_i),
        .cand_vld_o (cand_vld),
        .cand_idx_o (cand_idx),
        .cand_lvl_o (cand_lvl),
        .cand_grp_o (cand_grp)
    );

    irq_grant_ctl #(.IDX_W(IDX_W)) u_gnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cand_vld_i (cand_vld),
        .cand_idx_i (cand_idx),
        .cand_lvl_i (cand_lvl),
        .cand_grp_i (cand_grp),
        .cpu_lvl_i  (cpu_lvl_i),
        .win_vld_o  (win_vld_o),
        .win_idx_o  (win_idx_o),
        .win_lvl_o  (win_lvl_o),
        .win_grp_o  (win_grp_o),
        .gnt_o      (gnt_o)
    );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [NSRC-1:0]  evt_i,
    input logic             gie_i,
    input logic [3:0]       cpu_lvl_i,
    input logic             svc_i,
    input logic [IDX_W-1:0] svc_idx_i,
    input logic [NSRC-1:0]  pend_vec,
    input logic             win_vld_o,
    input logic [3:0]       win_lvl_o,
    input logic             gnt_o
);
    // R3
    gnt_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_o |-> $past(gie_i));

    // R3
    no_level_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_vld_o |-> (win_lvl_o != 4'd0));

    // R7
    above_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_vld_o |-> (win_lvl_o > $past(cpu_lvl_i)));

    // R8
    gnt_has_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_o |-> win_vld_o);

    // R8
    gnt_no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o && $stable(cpu_lvl_i)) |=> !gnt_o);

    // R9
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((pend_vec & $past(evt_i)) == $past(evt_i)));

    // R10
    svc_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (svc_i && !evt_i[svc_idx_i]) |=> !pend_vec[$past(svc_idx_i)]);
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .gie_i     (gie_i),
    .cpu_lvl_i (cpu_lvl_i),
    .svc_i     (svc_i),
    .svc_idx_i (svc_idx_i),
    .pend_vec  (pend_vec),
    .win_vld_o (win_vld_o),
    .win_lvl_o (win_lvl_o),
    .gnt_o     (gnt_o)
);

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;
    localparam int NSRC  = 32;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  evt = '0;
    logic             we = 1'b0;
    logic [IDX_W-1:0] widx = '0;
    logic [7:0]       wdata = '0;
    logic             gie = 1'b0;
    logic [3:0]       cpu = '0;
    logic             svc = 1'b0;
    logic [IDX_W-1:0] sidx = '0;
    logic             vld, gnt;
    logic [IDX_W-1:0] idx;
    logic [3:0]       lvl;
    logic [1:0]       grp;

    int errors = 0;
    int checks = 0;

    // Model state
    logic       m_pend [NSRC];
    logic       m_en   [NSRC];
    logic [3:0] m_lvl  [NSRC];
    logic [1:0] m_grp  [NSRC];
    logic       m_armed;
    logic [3:0] m_snap;
    logic       e_vld, e_gnt;
    logic [IDX_W-1:0] e_idx;
    logic [3:0] e_lvl;
    logic [1:0] e_grp;

    always #5 clk = ~clk;

    irq_arbiter #(.NSRC(NSRC)) i_irq_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cfg_we_i(we), .cfg_idx_i(widx),
        .cfg_data_i(wdata), .gie_i(gie), .cpu_lvl_i(cpu), .svc_i(svc), .svc_idx_i(sidx),
        .win_vld_o(vld), .win_idx_o(idx), .win_lvl_o(lvl), .win_grp_o(grp), .gnt_o(gnt)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NSRC; i++) begin
            m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_grp[i] = 0;
        end
        m_armed = 1; m_snap = 0;
    endtask

    // R4 R5 R6 R3 R7 R8: expected outputs from the pre-edge model state
    task automatic model_eval();
        logic c_vld; logic [5:0] best; logic [IDX_W-1:0] bi; logic rearm;
        c_vld = 0; best = 0; bi = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (gie && m_pend[i] && m_en[i] && m_lvl[i] != 0) begin
                if (!c_vld || {m_lvl[i], m_grp[i]} > best) begin
                    c_vld = 1; best = {m_lvl[i], m_grp[i]}; bi = IDX_W'(i);
                end
            end
        end
        e_vld = c_vld && (best[5:2] > cpu);
        e_idx = e_vld ? bi : '0;
        e_lvl = e_vld ? best[5:2] : '0;
        e_grp = e_vld ? best[1:0] : '0;
        rearm = m_armed || (cpu != m_snap);
        e_gnt = e_vld && rearm;
        m_armed = e_gnt ? 1'b0 : (rearm || !e_vld);
        if (e_gnt) m_snap = cpu;
    endtask

    // R2 R9 R10: write, then service clear, then event set
    task automatic model_update();
        if (we) begin
            m_pend[widx] = wdata[7]; m_en[widx] = wdata[6];
            m_lvl[widx] = wdata[5:2]; m_grp[widx] = wdata[1:0];
        end
        if (svc) m_pend[sidx] = 0;
        for (int i = 0; i < NSRC; i++) if (evt[i]) m_pend[i] = 1;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_eval();
        model_update();
        #1;
        chk({tag, " vld"}, 32'(vld), 32'(e_vld));
        chk({tag, " idx"}, 32'(idx), 32'(e_idx));
        chk({tag, " lvl"}, 32'(lvl), 32'(e_lvl));
        chk({tag, " grp"}, 32'(grp), 32'(e_grp));
        chk({tag, " gnt"}, 32'(gnt), 32'(e_gnt));
        @(negedge clk);
        we = 0; svc = 0; evt = '0;
    endtask

    task automatic wr(int s, logic [7:0] d);
        we = 1; widx = IDX_W'(s); wdata = d;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 vld", 32'(vld), 0); chk("R1 gnt", 32'(gnt), 0);
        chk("R1 idx", 32'(idx), 0); chk("R1 lvl", 32'(lvl), 0);
        chk("R1 grp", 32'(grp), 0);
        gie = 1; cpu = 0;
        step("R1 idle");

        // R2 layout: pend=1 en=1 lvl=1 grp=1
        wr(3, 8'hC5); step("R2"); step("R2");
        chk("R2 idx", 32'(idx), 3); chk("R2 lvl", 32'(lvl), 1);
        chk("R2 grp", 32'(grp), 1); chk("R8 first gnt", 32'(gnt), 1);

        // R3 participation
        gie = 0; step("R3"); step("R3"); chk("R3 gie off", 32'(vld), 0);
        gie = 1; wr(3, 8'h85); step("R3"); step("R3"); chk("R3 en off", 32'(vld), 0);
        wr(3, 8'hC1); step("R3"); step("R3"); chk("R3 level0", 32'(vld), 0);
        wr(3, 8'hC5); step("R3"); step("R3");

        // R4 level beats group
        wr(5, 8'hE4); step("R4"); step("R4");
        chk("R4 idx", 32'(idx), 5); chk("R4 lvl", 32'(lvl), 9);
        // R5 group tiebreak
        wr(7, 8'hE6); step("R5"); step("R5");
        chk("R5 idx", 32'(idx), 7); chk("R5 grp", 32'(grp), 2);
        // R6 index tiebreak
        wr(2, 8'hE6); step("R6"); step("R6");
        chk("R6 idx", 32'(idx), 2);

        // R7 cpu level compare
        cpu = 9; step("R7"); chk("R7 equal", 32'(vld), 0);
        cpu = 8; step("R7"); chk("R7 above", 32'(vld), 1);
        chk("R8 rearm by idle", 32'(gnt), 1);
        // R8 no repeat while cpu holds
        for (int k = 0; k < 3; k++) begin
            step("R8"); chk("R8 hold", 32'(gnt), 0);
        end
        cpu = 7; step("R8"); chk("R8 cpu change", 32'(gnt), 1);
        step("R8"); chk("R8 single", 32'(gnt), 0);
        cpu = 0;

        // R9 event sets flag
        wr(10, 8'h7C); step("R9"); step("R9"); chk("R9 not yet", 32'(idx), 2);
        evt[10] = 1; step("R9"); step("R9");
        chk("R9 idx", 32'(idx), 10); chk("R9 lvl", 32'(lvl), 15);

        // R10 service clear, event wins
        svc = 1; sidx = 10; step("R10"); step("R10"); chk("R10 clear", 32'(idx), 2);
        svc = 1; sidx = 2; evt[2] = 1; step("R10"); step("R10");
        chk("R10 set wins", 32'(idx), 2);
        svc = 1; sidx = 2; wr(2, 8'hE6); step("R10"); step("R10");
        chk("R10 over write", 32'(idx), 7);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3) == 0) wr($urandom_range(NSRC-1), 8'($urandom));
            if ($urandom_range(7) == 0) evt[$urandom_range(NSRC-1)] = 1;
            if ($urandom_range(3) == 0) begin
                svc = 1;
                sidx = ($urandom_range(1) == 0) ? idx : IDX_W'($urandom_range(NSRC-1));
            end
            gie = ($urandom_range(15) != 0);
            if ($urandom_range(7) == 0) cpu = 4'($urandom_range(15));
            step("R4 R5 R6 R7 R8 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule